// File: doc/BRIEF.md
# Cyclic (15,7) Majority-Decodable Code Encoder

This block turns a 7-bit data word into a 15-bit protected word for storage in a memory that guards against soft errors. The code is a cyclic Euclidean-geometry LDPC code with minimum distance 5. It corrects any two bit flips with a one-step majority-logic decoder, which sits elsewhere. The encoding is systematic. The data bits pass unchanged into the low seven positions of the stored word. The eight upper positions carry check bits, and each check bit is a fixed XOR of a subset of the data bits.

The check bits are the remainder of x^8·m(x) divided by the generator polynomial g(x) = 1 + x^4 + x^6 + x^7 + x^8, where m(x) is the data word with bit i as the coefficient of x^i. This remainder is the standard systematic cyclic codeword rotated by seven places. The result is still a codeword, because the code is cyclic. The XOR masks for the check bits are derived from g(x) when the design is elaborated.

A parameter selects between two placements in a memory write path. In one, the output is registered one clock behind the input strobe. In the other, the output is combinational and follows the input in the same cycle.

Top module: `eg_ldpc_encoder`

## Requirements
- R1: Output bits 6..0 equal the data bits 6..0 of the accepted input word, bit for bit.
- R2: Taking output bit i as the coefficient of x^i, the 15-bit output polynomial divides exactly by g(x) = 1 + x^4 + x^6 + x^7 + x^8 (zero syndrome) whenever the output valid is high.
- R3: Every codeword produced from a nonzero data word has Hamming weight of at least 5, and at least one of them has weight exactly 5.
- R4: An all-zero data word produces the all-zero codeword.
- R5: Encoding is linear: the codeword of a XOR b equals the XOR of the codewords of a and b.
- R6: In registered mode (REGISTERED=1), the output valid is high exactly in the cycle after an input valid cycle, and the codeword is shown with it. Without an input valid, the output codeword keeps its last value.
- R7: In combinational mode (REGISTERED=0), the output valid equals the input valid in the same cycle. The output is the codeword while the valid is high and all zeros while it is low. It matches the registered mode codeword for the same data.
- R8: While reset (active low) is asserted and after it is released with no input, the output valid is low and the registered codeword is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Data word strobe |
| inData | input | 7 | Data word to encode |
| outValid | output | 1 | Codeword strobe |
| outCode | output | 15 | Systematic codeword: data in bits 6..0, check bits in 14..7 |

## Verification
All 128 data words are applied back to back. Each output is checked against three properties that are derived separately from one another: the systematic copy, exact division by g(x) computed by long division in the bench, and weight. Together these pin down a unique codeword for each data word, so one wrong mask bit shows up. The lowest weight seen must be exactly 5, which separates a correct code from a weaker one that still passes the division test. All pairs of stored codewords are checked for linearity. Idle cycles with changing data confirm that the registered word holds and that the combinational word drops to zero.

// File: rtl/eg_enc_pkg.sv
package eg_enc_pkg;
  localparam int INFO_W  = 7;
  localparam int CODE_W  = 15;
  localparam int CHECK_W = CODE_W - INFO_W;
  // generator polynomial, bit i = coefficient of x^i
  localparam logic [CHECK_W:0] GEN_POLY = 9'h1D1;
  localparam logic [CHECK_W-1:0] GEN_LOW = GEN_POLY[CHECK_W-1:0];

  typedef struct packed {
    logic capture;
    logic codeValid;
  } encStrobes_t;

  // x^p mod g(x)
  function automatic logic [CHECK_W-1:0] powRem(input int p);
    logic [CHECK_W-1:0] r;
    logic top;
    r = CHECK_W'(1);
    for (int s = 0; s < p; s++) begin
      top = r[CHECK_W-1];
      r = {r[CHECK_W-2:0], 1'b0};
      if (top) r = r ^ GEN_LOW;
    end
    return r;
  endfunction

  // data bits feeding check bit j
  function automatic logic [INFO_W-1:0] checkMask(input int j);
    logic [INFO_W-1:0] m;
    logic [CHECK_W-1:0] rem;
    m = '0;
    for (int i = 0; i < INFO_W; i++) begin
      rem = powRem(CHECK_W + i);
      m[i] = rem[j];
    end
    return m;
  endfunction

  // remainder of a codeword polynomial by g(x)
  function automatic logic [CHECK_W-1:0] syndromeOf(input logic [CODE_W-1:0] c);
    logic [CHECK_W-1:0] r;
    logic top;
    r = '0;
    for (int i = CODE_W - 1; i >= 0; i--) begin
      top = r[CHECK_W-1];
      r = {r[CHECK_W-2:0], c[i]};
      if (top) r = r ^ GEN_LOW;
    end
    return r;
  endfunction
endpackage

// File: rtl/eg_enc_ctrl.sv
module eg_enc_ctrl
  import eg_enc_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output encStrobes_t strobes
);
  logic validOut;

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validOut <= 1'b0;
        else       validOut <= inValid;
      end

      p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> validOut);
      p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !validOut);
    end else begin : g_comb
      always_comb validOut = inValid;
    end
  endgenerate

  always_comb begin
    strobes.capture   = inValid;
    strobes.codeValid = validOut;
  end
endmodule

// File: rtl/eg_enc_datapath.sv
module eg_enc_datapath
  import eg_enc_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  encStrobes_t       strobes,
  input  logic [INFO_W-1:0] dataIn,
  output logic [CODE_W-1:0] codeOut
);
  logic [CHECK_W-1:0] checkBits;
  logic [CODE_W-1:0]  codeComb;

  generate
    for (genvar j = 0; j < CHECK_W; j++) begin : g_check
      localparam logic [INFO_W-1:0] MASK = checkMask(j);
      always_comb checkBits[j] = ^(dataIn & MASK);
    end
  endgenerate

  always_comb codeComb = {checkBits, dataIn};

  generate
    if (REGISTERED) begin : g_reg
      logic [CODE_W-1:0] codeQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                codeQ <= '0;
        else if (strobes.capture) codeQ <= codeComb;
      end
      always_comb codeOut = codeQ;

      p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.capture |=> $stable(codeOut));
      p_systematic_r1: assert property (@(posedge clk) disable iff (!rstN)
        strobes.capture |=> codeOut[INFO_W-1:0] == $past(dataIn));
    end else begin : g_comb
      always_comb codeOut = strobes.capture ? codeComb : '0;

      p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.codeValid |-> codeOut == '0);
    end
  endgenerate

  p_syndrome_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.codeValid |-> syndromeOf(codeOut) == '0);
  p_zero_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataIn == '0 |-> checkBits == '0);
endmodule

// File: rtl/eg_ldpc_encoder.sv
module eg_ldpc_encoder
  import eg_enc_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [INFO_W-1:0] inData,
  output logic              outValid,
  output logic [CODE_W-1:0] outCode
);
  encStrobes_t strobes;

  eg_enc_ctrl #(.REGISTERED(REGISTERED)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes)
  );

  eg_enc_datapath #(.REGISTERED(REGISTERED)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (inData),
    .codeOut (outCode)
  );

  always_comb outValid = strobes.codeValid;
endmodule

// File: tb/eg_ldpc_encoder_test.sv
module eg_ldpc_encoder_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [6:0] inData = '0;
  logic regValid, combValid;
  logic [14:0] regCode, combCode;
  logic [14:0] cwTable [128];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eg_ldpc_encoder #(.REGISTERED(1'b1)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(regValid), .outCode(regCode));

  eg_ldpc_encoder #(.REGISTERED(1'b0)) uutComb (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(combValid), .outCode(combCode));

  function automatic logic [7:0] benchRem(input logic [14:0] v);
    logic [14:0] w = v;
    for (int b = 14; b >= 8; b--)
      if (w[b]) w = w ^ (15'(9'h1D1) << (b - 8));
    return w[7:0];
  endfunction

  function automatic int weightOf(input logic [14:0] v);
    int n = 0;
    for (int b = 0; b < 15; b++) n += int'(v[b]);
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    int minW;
    int minCount;
    // R8: reset state
    repeat (2) @(negedge clk);
    check(regValid == 1'b0, "R8 valid in reset", 15'(regValid), 15'd0);
    check(regCode == '0, "R8 code in reset", regCode, 15'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(regValid == 1'b0, "R8 valid after reset", 15'(regValid), 15'd0);
    check(regCode == '0, "R8 code after reset", regCode, 15'd0);
    check(combValid == 1'b0, "R8 comb valid idle", 15'(combValid), 15'd0);

    // sweep of all data words, back to back
    for (int d = 0; d < 128; d++) begin
      inValid = 1'b1;
      inData = 7'(d);
      #1;
      check(combValid == 1'b1, "R7 comb valid same cycle", 15'(combValid), 15'd1);
      check(combCode[6:0] == 7'(d), "R1 comb systematic", combCode, 15'(d));
      check(benchRem(combCode) == 8'd0, "R2 comb syndrome", 15'(benchRem(combCode)), 15'd0);
      cwTable[d] = combCode;
      @(negedge clk);
      check(regValid == 1'b1, "R6 registered valid latency", 15'(regValid), 15'd1);
      check(regCode[6:0] == 7'(d), "R1 registered systematic", regCode, 15'(d));
      check(benchRem(regCode) == 8'd0, "R2 registered syndrome", 15'(benchRem(regCode)), 15'd0);
      check(regCode == cwTable[d], "R7 modes agree", combCode, regCode);
    end

    // R6/R7: idle cycles with changing data
    inValid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      inData = 7'(k * 37 + 5);
      #1;
      check(combValid == 1'b0, "R7 comb valid low", 15'(combValid), 15'd0);
      check(combCode == '0, "R7 comb idle zero", combCode, 15'd0);
      @(negedge clk);
      check(regValid == 1'b0, "R6 registered valid low", 15'(regValid), 15'd0);
      check(regCode == cwTable[127], "R6 registered hold", regCode, cwTable[127]);
    end

    // R4: zero word
    check(cwTable[0] == '0, "R4 zero codeword", cwTable[0], 15'd0);

    // R3: minimum weight
    minW = 15;
    minCount = 0;
    for (int d = 1; d < 128; d++) begin
      if (weightOf(cwTable[d]) < minW) minW = weightOf(cwTable[d]);
      if (weightOf(cwTable[d]) == 5) minCount++;
    end
    check(minW == 5, "R3 minimum weight", 15'(minW), 15'd5);
    check(minCount > 0, "R3 weight five present", 15'(minCount), 15'd1);

    // R5: linearity over all pairs
    for (int a = 0; a < 128; a++)
      for (int b = a + 1; b < 128; b++)
        check(cwTable[a ^ b] == (cwTable[a] ^ cwTable[b]), "R5 linearity",
              cwTable[a ^ b], cwTable[a] ^ cwTable[b]);

    finish();
  end
endmodule